// File: doc/BRIEF.md
# Ethernet Controller Operating-Mode Access Gate

This block keeps the byte-wide command/mode register of a small Ethernet controller. It uses the two-bit operating-mode field in the top of that byte to gate two kinds of traffic. The first is host writes into a small bank of protected configuration registers. The second is frame exchange between the network side and the host. Every field value is matched exactly against a full encoding. A single set bit in the field is never enough to open a path.

The host reaches the mode register and the protected bank through one byte port with an address. Address zero selects the mode register. Addresses one to `NUM_CFG` select the protected registers. A write to a protected register commits only in configuration-write mode, and a one-cycle pulse reports each commit. On the receive side, the block shows whether it can take a frame. Each offered frame is answered one cycle later with either an accept pulse or a drop pulse. A refused frame is never partly stored.

Top module: `nic_opmode_gate`

## Requirements
- R1: Reset (synchronous, active high) clears the mode byte and every protected register to 0. After reset, `reg_rdata_o`, `cfg_we_o`, `rx_accept_o` and `rx_drop_o` are 0 and `rx_ready_o` is 1.
- R2: Bits 7:6 of the mode byte form the mode field: 00 normal, 01 autoload, 10 programming, 11 configuration-write. The whole byte written at address 0 reads back unchanged, and bits 5:0 have no effect on either gate.
- R3: A write to address 1..`NUM_CFG` while the mode field is exactly 11 stores the data in protected register (address-1). `cfg_we_o` is high in the following cycle.
- R4: A write to a protected register while the mode field is 00, 01 or 10 leaves that register unchanged and keeps `cfg_we_o` low.
- R5: `rx_ready_o` is high exactly while the mode field is 00.
- R6: A frame offered (`rx_offer_i` high at a clock edge) gives `rx_accept_o` in the next cycle if the mode field was 00, and `rx_drop_o` otherwise. The two pulses are never high together.
- R7: A new mode takes effect one cycle after its write. A request sampled at the same edge as the mode write is judged against the old mode.
- R8: `reg_rdata_o` shows, one cycle later, the register selected by `reg_addr_i` as it stood before that edge. Addresses above `NUM_CFG` read 0 and ignore writes.
- R9: Without an offer, neither `rx_accept_o` nor `rx_drop_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Write strobe for the byte port |
| reg_addr_i | input | ADDR_W | Register select (0 = mode byte) |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| cfg_we_o | output | 1 | Pulse: a protected write was committed |
| rx_offer_i | input | 1 | A frame is offered by the network side |
| rx_ready_o | output | 1 | Receive path can accept a frame |
| rx_accept_o | output | 1 | Pulse: offered frame accepted |
| rx_drop_o | output | 1 | Pulse: offered frame refused and dropped |

## Verification
A corrupted mode field is visible at the ports almost at once. `rx_ready_o` follows it in the same cycle, and the next offer or protected write gives the wrong pulse one cycle later. A protected register that was stored wrongly stays hidden until it is read back, and then shows one cycle after the address is presented. For that reason the reference model compares the read data on every cycle, and the sequences read back each register after blocked and committed writes. Mode changes are placed on the same edge as requests so that any off-by-one in when a mode takes effect shows up as a wrong pulse.

// File: rtl/nic_mode_pkg.sv
package nic_mode_pkg;

  // Operating-mode field encodings (bits 7:6 of the mode byte)
  typedef enum logic [1:0] {
    OPM_NORMAL   = 2'b00,
    OPM_AUTOLOAD = 2'b01,
    OPM_PROGRAM  = 2'b10,
    OPM_CFGWRITE = 2'b11
  } opmode_e;

  localparam int OPM_W = 2;

endpackage

// File: rtl/opmode_reg.sv
module opmode_reg
  import nic_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] byte_o,
  output opmode_e           mode_o
);

  localparam int FIELD_LSB = DATA_W - OPM_W;

  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
    end else if (wr_i) begin
      byte_q <= wdata_i;
    end
  end

  assign byte_o = byte_q;
  assign mode_o = opmode_e'(byte_q[DATA_W-1:FIELD_LSB]);

endmodule

// File: rtl/opmode_decode.sv
module opmode_decode
  import nic_mode_pkg::*;
(
  input  opmode_e mode_i,
  output logic    cfg_open_o,
  output logic    net_open_o
);

  // Exact-match decoding: no single bit opens a path on its own.
  always_comb begin
    cfg_open_o = 1'b0;
    net_open_o = 1'b0;
    unique case (mode_i)
      OPM_NORMAL:   net_open_o = 1'b1;
      OPM_CFGWRITE: cfg_open_o = 1'b1;
      OPM_AUTOLOAD,
      OPM_PROGRAM:  ;
      default:      ;
    endcase
  end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int DATA_W  = 8,
  parameter int NUM_CFG = 4,
  parameter int IDX_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           open_i,
  output logic                           we_o,
  output logic [NUM_CFG-1:0][DATA_W-1:0] regs_o
);

  logic commit;
  logic we_q;

  assign commit = req_i & open_i;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (commit && (idx_i == IDX_W'(g))) begin
        q <= wdata_i;
      end
    end
    assign regs_o[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b0;
    else     we_q <= commit;
  end

  assign we_o = we_q;

endmodule

// File: rtl/rx_gate.sv
module rx_gate (
  input  logic clk,
  input  logic rst,
  input  logic offer_i,
  input  logic open_i,
  output logic accept_o,
  output logic drop_o
);

  logic accept_q;
  logic drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_q <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      accept_q <= offer_i &  open_i;
      drop_q   <= offer_i & ~open_i;
    end
  end

  assign accept_o = accept_q;
  assign drop_o   = drop_q;

endmodule

// File: rtl/nic_opmode_gate.sv
module nic_opmode_gate
  import nic_mode_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_CFG = 4,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              cfg_we_o,
  input  logic              rx_offer_i,
  output logic              rx_ready_o,
  output logic              rx_accept_o,
  output logic              rx_drop_o
);

  localparam int IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

  logic                           sel_mode;
  logic                           sel_cfg;
  logic [IDX_W-1:0]               cfg_idx;
  logic [DATA_W-1:0]              mode_byte;
  opmode_e                        cur_mode;
  logic                           cfg_open;
  logic                           net_open;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_regs;
  logic [DATA_W-1:0]              rd_next;
  logic [DATA_W-1:0]              rd_q;

  assign sel_mode = (reg_addr_i == '0);
  assign sel_cfg  = (reg_addr_i != '0) && (reg_addr_i <= ADDR_W'(NUM_CFG));
  assign cfg_idx  = IDX_W'(reg_addr_i - ADDR_W'(1));

  opmode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr_i & sel_mode),
    .wdata_i (reg_wdata_i),
    .byte_o  (mode_byte),
    .mode_o  (cur_mode)
  );

  opmode_decode u_dec (
    .mode_i     (cur_mode),
    .cfg_open_o (cfg_open),
    .net_open_o (net_open)
  );

  cfg_bank #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .req_i   (reg_wr_i & sel_cfg),
    .idx_i   (cfg_idx),
    .wdata_i (reg_wdata_i),
    .open_i  (cfg_open),
    .we_o    (cfg_we_o),
    .regs_o  (cfg_regs)
  );

  rx_gate u_rx (
    .clk      (clk),
    .rst      (rst),
    .offer_i  (rx_offer_i),
    .open_i   (net_open),
    .accept_o (rx_accept_o),
    .drop_o   (rx_drop_o)
  );

  always_comb begin
    rd_next = '0;
    if (sel_mode)     rd_next = mode_byte;
    else if (sel_cfg) rd_next = cfg_regs[cfg_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign reg_rdata_o = rd_q;
  assign rx_ready_o  = net_open;

endmodule

// File: rtl/nic_opmode_gate_chk.sv
module nic_opmode_gate_chk #(
  parameter int DATA_W  = 8,
  parameter int NUM_CFG = 4,
  parameter int ADDR_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              cfg_we_o,
  input logic              rx_offer_i,
  input logic              rx_ready_o,
  input logic              rx_accept_o,
  input logic              rx_drop_o,
  input logic [1:0]        mode_field
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!cfg_we_o && !rx_accept_o && !rx_drop_o));

  // R3
  commit_needs_cfgwrite_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we_o |-> ($past(mode_field) == 2'b11 && $past(reg_wr_i)));

  // R5
  ready_rise_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready_o) |-> $past(reg_wr_i && reg_addr_i == '0));

  // R6
  accept_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_offer_i && rx_ready_o) |=> (rx_accept_o && !rx_drop_o));

  // R6
  drop_when_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_offer_i && !rx_ready_o) |=> (rx_drop_o && !rx_accept_o));

  // R9
  no_pulse_without_offer_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_offer_i |=> (!rx_accept_o && !rx_drop_o));

  // R8
  reserved_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i > ADDR_W'(NUM_CFG)) |=> (reg_rdata_o == '0));

endmodule

bind nic_opmode_gate nic_opmode_gate_chk #(
  .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .cfg_we_o    (cfg_we_o),
  .rx_offer_i  (rx_offer_i),
  .rx_ready_o  (rx_ready_o),
  .rx_accept_o (rx_accept_o),
  .rx_drop_o   (rx_drop_o),
  .mode_field  (cur_mode)
);

// File: tb/test_nic_opmode_gate.sv
`timescale 1ns/1ps
module test_nic_opmode_gate;

  localparam int DATA_W  = 8;
  localparam int NUM_CFG = 4;
  localparam int ADDR_W  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              cfg_we;
  logic              rx_offer = 1'b0;
  logic              rx_ready;
  logic              rx_accept;
  logic              rx_drop;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_mode;
  int m_cfg [NUM_CFG];

  always #2.5 clk = ~clk;

  nic_opmode_gate #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W)) i_nic_opmode_gate (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .cfg_we_o    (cfg_we),
    .rx_offer_i  (rx_offer),
    .rx_ready_o  (rx_ready),
    .rx_accept_o (rx_accept),
    .rx_drop_o   (rx_drop)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, step the model, compare at the next negedge.
  task automatic cycle(input bit wr, input int addr, input int data, input bit offer,
                       input string tag);
    int fld;
    int e_rd;
    bit e_we;
    bit e_acc;
    bit e_drop;
    bit e_rdy;
    reg_wr    = wr;
    reg_addr  = addr[ADDR_W-1:0];
    reg_wdata = data[DATA_W-1:0];
    rx_offer  = offer;
    fld = m_mode / 64;
    if (addr == 0) e_rd = m_mode;
    else if (addr <= NUM_CFG) e_rd = m_cfg[addr-1];
    else e_rd = 0;
    e_we   = wr && addr >= 1 && addr <= NUM_CFG && fld == 3;
    e_acc  = offer && fld == 0;
    e_drop = offer && fld != 0;
    if (wr && addr == 0) m_mode = data % 256;
    if (e_we) m_cfg[addr-1] = data % 256;
    e_rdy = (m_mode / 64) == 0;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rdata",  int'(reg_rdata), e_rd);
    chk(tag, "cfg_we", int'(cfg_we),    int'(e_we));
    chk(tag, "accept", int'(rx_accept), int'(e_acc));
    chk(tag, "drop",   int'(rx_drop),   int'(e_drop));
    chk(tag, "ready",  int'(rx_ready),  int'(e_rdy));
  endtask

  task automatic idle(input string tag);
    cycle(1'b0, 0, 0, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lfsr;
    m_mode = 0;
    for (int i = 0; i < NUM_CFG; i++) m_cfg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    chk("R1", "rdata",  int'(reg_rdata), 0);
    chk("R1", "cfg_we", int'(cfg_we),    0);
    chk("R1", "accept", int'(rx_accept), 0);
    chk("R1", "drop",   int'(rx_drop),   0);
    chk("R1", "ready",  int'(rx_ready),  1);
    for (int a = 0; a <= NUM_CFG; a++) cycle(1'b0, a, 0, 1'b0, "R1");

    // R6: normal mode accepts, back to back
    cycle(1'b0, 0, 0, 1'b1, "R6");
    cycle(1'b0, 0, 0, 1'b1, "R6");
    idle("R9");

    // R4: protected write in normal mode is blocked
    cycle(1'b1, 1, 8'hA5, 1'b0, "R4");
    cycle(1'b0, 1, 0, 1'b0, "R4");
    idle("R4");

    // R7: mode write to autoload with coincident offer uses old mode
    cycle(1'b1, 0, 8'h40, 1'b1, "R7");
    cycle(1'b0, 0, 0, 1'b1, "R7");
    cycle(1'b0, 0, 0, 1'b0, "R5");
    // R4: autoload and programming block protected writes
    cycle(1'b1, 2, 8'h11, 1'b0, "R4");
    cycle(1'b0, 2, 0, 1'b0, "R4");
    cycle(1'b1, 0, 8'h80, 1'b0, "R2");
    cycle(1'b1, 2, 8'h22, 1'b1, "R4");
    cycle(1'b0, 2, 0, 1'b0, "R4");

    // R3: configuration-write mode commits
    cycle(1'b1, 0, 8'hC0, 1'b0, "R2");
    cycle(1'b1, 2, 8'h3C, 1'b1, "R3");
    for (int a = 1; a <= NUM_CFG; a++) cycle(1'b1, a, 16 * a + 7, 1'b0, "R3");
    for (int a = 1; a <= NUM_CFG; a++) cycle(1'b0, a, 0, 1'b0, "R3");

    // R8: reserved addresses
    for (int a = NUM_CFG + 1; a < (1 << ADDR_W); a++) cycle(1'b1, a, 8'hEE, 1'b0, "R8");
    for (int a = NUM_CFG + 1; a < (1 << ADDR_W); a++) cycle(1'b0, a, 0, 1'b0, "R8");

    // R2: low bits stored, no effect on gating
    cycle(1'b1, 0, 8'hFF, 1'b0, "R2");
    cycle(1'b1, 3, 8'h99, 1'b1, "R2");
    cycle(1'b1, 0, 8'h3F, 1'b0, "R2");
    cycle(1'b1, 3, 8'h55, 1'b1, "R2");
    cycle(1'b0, 3, 0, 1'b0, "R2");
    cycle(1'b0, 0, 0, 1'b0, "R2");
    cycle(1'b1, 0, 8'h7F, 1'b1, "R7");
    cycle(1'b1, 4, 8'h01, 1'b1, "R4");
    cycle(1'b1, 0, 8'hBF, 1'b1, "R5");
    cycle(1'b1, 0, 8'h00, 1'b1, "R7");
    cycle(1'b0, 0, 0, 1'b1, "R6");

    // R7: mixed pseudo-random traffic against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      cycle(lfsr[0], (lfsr >> 1) % 8, (lfsr >> 4) % 256, lfsr[12], "R7");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule